// File: doc/BRIEF.md
# Link Receiver Physical Trailer Appender

This block sits in a receive path directly behind a link decoder. The decoder hands it a stream of symbols, and each symbol is one of three things: a data byte, a begin-of-event marker or an end-of-event marker. Each symbol can also carry a receive-error flag. The block forwards the stream unchanged. While it does so, it keeps a running XOR of every data byte in the current event and a sticky flag that records any receive error.

When the end-of-event marker arrives, the block holds that marker at its input. It first emits two extra data bytes, the physical trailer, and only then forwards the marker. The first trailer byte is the longitudinal parity of the event. The second is a status byte. It holds the error flag, a type code that identifies the inserting card, and a field of configuration bits. Because two bytes are inserted, the 16-byte alignment of the event is deliberately broken.

Both sides of the block use a valid/ready handshake. The output is registered, and the block follows downstream backpressure. It loses no symbol and sends none twice.

Top module: `ltp_trailer_appender`

## Requirements
- R1: The kind code is 2 bits: 0 is data, 1 is begin-of-event, 2 is end-of-event, and 3 is an auxiliary data byte. Every symbol other than end-of-event leaves the block with the same kind and data, in the order it was accepted.
- R2: The first data symbol emitted after the last data byte of an event carries the XOR of all data bytes (kinds 0 and 3) accepted since the latest begin-of-event. This symbol is kind 0.
- R3: The next symbol is a kind 0 status byte. Bit 7 is 1 if any data or begin-of-event symbol of the event had its error flag set. Bits 6:2 equal the configuration bits input. Bits 1:0 equal the type ID input. The status byte is never folded into any parity value.
- R4: A begin-of-event clears both the parity and the error flag. Data bytes and errors that arrive before it affect neither.
- R5: The end-of-event marker is forwarded exactly once, directly after the status byte.
- R6: While an end-of-event marker waits at the input, in_ready_o stays low for exactly the two output loads that carry the trailer bytes. With no backpressure this is two cycles.
- R7: While out_valid_o is high and out_ready_i is low, the output kind and data stay stable. Under any backpressure pattern no symbol is dropped or duplicated.
- R8: During and directly after reset, out_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input symbol valid |
| in_ready_o | output | 1 | Input symbol accepted when high together with valid |
| in_kind_i | input | 2 | Input symbol kind (0 data, 1 begin, 2 end, 3 auxiliary data) |
| in_data_i | input | 8 | Input data byte |
| in_err_i | input | 1 | Receive error flagged on this symbol |
| type_id_i | input | 2 | Type ID of the inserting card, placed in status bits 1:0 |
| cfg_bits_i | input | 5 | Configuration value placed in status bits 6:2 |
| out_valid_o | output | 1 | Output symbol valid |
| out_ready_i | input | 1 | Downstream ready |
| out_kind_o | output | 2 | Output symbol kind |
| out_data_o | output | 8 | Output data byte |

## Verification
The hardest case to reach is an end-of-event marker that is held while the output register is itself stalled. In that case the parity byte, the status byte and the marker each have to wait through downstream backpressure without slipping or repeating. The bench produces it by toggling out_ready_i in an irregular pattern while complete events stream in. It then compares every captured output symbol against the expected sequence. It also drives stray data and errors with no preceding begin marker, which shows that the clearing rule is applied per event.

// File: rtl/ltp_pkg.sv
package ltp_pkg;
  typedef enum logic [1:0] {
    K_DATA = 2'd0,
    K_BOE  = 2'd1,
    K_EOE  = 2'd2,
    K_AUX  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ST_PASS = 2'd0,
    ST_STS  = 2'd1,
    ST_EOE  = 2'd2
  } st_e;

  typedef enum logic [1:0] {
    SEL_IN  = 2'd0,
    SEL_PAR = 2'd1,
    SEL_STS = 2'd2
  } sel_e;
endpackage

// File: rtl/ltp_parity_acc.sv
module ltp_parity_acc
  import ltp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [1:0]        kind_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              err_i,
  output logic [DATA_W-1:0] parity_o,
  output logic              err_o
);
  logic [DATA_W-1:0] par_q;
  logic              err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q <= '0;
      err_q <= 1'b0;
    end else if (fire_i) begin
      unique case (kind_i)
        K_BOE: begin
          par_q <= '0;
          err_q <= err_i;
        end
        K_EOE: ;
        default: begin
          par_q <= par_q ^ data_i;
          err_q <= err_q | err_i;
        end
      endcase
    end
  end

  assign parity_o = par_q;
  assign err_o    = err_q;

  AST_PAR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fire_i && kind_i == K_BOE) |-> par_q == '0); // R4
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !(fire_i && kind_i == K_BOE) |=> err_q); // R3
endmodule

// File: rtl/ltp_trailer_seq.sv
module ltp_trailer_seq
  import ltp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_en_i,
  input  logic       in_valid_i,
  input  logic       in_is_eoe_i,
  output logic       in_ready_o,
  output logic       nxt_valid_o,
  output logic [1:0] sel_o,
  output logic [1:0] state_o
);
  st_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    in_ready_o  = 1'b0;
    nxt_valid_o = in_valid_i;
    sel_o       = SEL_IN;
    unique case (state_q)
      ST_PASS: begin
        if (in_valid_i && in_is_eoe_i) begin
          // hold the marker, emit parity first
          sel_o       = SEL_PAR;
          nxt_valid_o = 1'b1;
          if (load_en_i) state_d = ST_STS;
        end else begin
          in_ready_o = load_en_i;
        end
      end
      ST_STS: begin
        sel_o       = SEL_STS;
        nxt_valid_o = 1'b1;
        if (load_en_i) state_d = ST_EOE;
      end
      ST_EOE: begin
        in_ready_o = load_en_i;
        if (load_en_i && in_valid_i) state_d = ST_PASS;
      end
      default: state_d = ST_PASS;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PASS;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_STS_FROM_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_STS |-> $past(state_q) != ST_EOE); // R6
endmodule

// File: rtl/ltp_out_reg.sv
module ltp_out_reg #(
  parameter int DATA_W = 8,
  parameter int KIND_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nxt_valid_i,
  input  logic [KIND_W-1:0] nxt_kind_i,
  input  logic [DATA_W-1:0] nxt_data_i,
  input  logic              out_ready_i,
  output logic              load_en_o,
  output logic              out_valid_o,
  output logic [KIND_W-1:0] out_kind_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic              vld_q;
  logic [KIND_W-1:0] kind_q;
  logic [DATA_W-1:0] data_q;

  assign load_en_o = !vld_q || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      kind_q <= '0;
      data_q <= '0;
    end else if (load_en_o) begin
      vld_q  <= nxt_valid_i;
      kind_q <= nxt_kind_i;
      data_q <= nxt_data_i;
    end
  end

  assign out_valid_o = vld_q;
  assign out_kind_o  = kind_q;
  assign out_data_o  = data_q;

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && !out_ready_i |=> vld_q && $stable(kind_q) && $stable(data_q)); // R7
endmodule

// File: rtl/ltp_trailer_appender.sv
module ltp_trailer_appender
  import ltp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ID_W   = 2,
  localparam int CFG_W = DATA_W - 1 - ID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [1:0]        in_kind_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_err_i,
  input  logic [ID_W-1:0]   type_id_i,
  input  logic [CFG_W-1:0]  cfg_bits_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [1:0]        out_kind_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic              fire;
  logic              load_en;
  logic              nxt_valid;
  logic [1:0]        sel;
  logic [1:0]        state;
  logic [1:0]        nxt_kind;
  logic [DATA_W-1:0] nxt_data;
  logic [DATA_W-1:0] parity;
  logic              err_flag;

  assign fire = in_valid_i && in_ready_o;

  ltp_parity_acc #(.DATA_W(DATA_W)) u_par (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .kind_i   (in_kind_i),
    .data_i   (in_data_i),
    .err_i    (in_err_i),
    .parity_o (parity),
    .err_o    (err_flag)
  );

  ltp_trailer_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_en_i   (load_en),
    .in_valid_i  (in_valid_i),
    .in_is_eoe_i (in_kind_i == K_EOE),
    .in_ready_o  (in_ready_o),
    .nxt_valid_o (nxt_valid),
    .sel_o       (sel),
    .state_o     (state)
  );

  always_comb begin
    nxt_kind = in_kind_i;
    nxt_data = in_data_i;
    unique case (sel)
      SEL_PAR: begin
        nxt_kind = K_DATA;
        nxt_data = parity;
      end
      SEL_STS: begin
        nxt_kind = K_DATA;
        nxt_data = {err_flag, cfg_bits_i, type_id_i};
      end
      default: ;
    endcase
  end

  ltp_out_reg #(.DATA_W(DATA_W), .KIND_W(2)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nxt_valid_i (nxt_valid),
    .nxt_kind_i  (nxt_kind),
    .nxt_data_i  (nxt_data),
    .out_ready_i (out_ready_i),
    .load_en_o   (load_en),
    .out_valid_o (out_valid_o),
    .out_kind_o  (out_kind_o),
    .out_data_o  (out_data_o)
  );

  AST_STS_HAS_PAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_STS |-> out_valid_o && out_kind_o == K_DATA); // R2
  AST_EOE_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_kind_i == K_EOE && in_ready_o |-> out_valid_o && out_kind_o == K_DATA); // R6
  AST_RST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !out_valid_o); // R8
endmodule

// File: tb/ltp_trailer_appender_tb.sv
`timescale 1ns/1ps
module ltp_trailer_appender_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_kind = 2'd0;
  logic [7:0] in_data = 8'h00;
  logic       in_err = 1'b0;
  logic [1:0] type_id = 2'd0;
  logic [4:0] cfg_bits = 5'd0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [1:0] out_kind;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  ltp_trailer_appender dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_kind_i(in_kind),
    .in_data_i(in_data), .in_err_i(in_err),
    .type_id_i(type_id), .cfg_bits_i(cfg_bits),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_kind_o(out_kind), .out_data_o(out_data)
  );

  typedef struct packed {
    logic [31:0] bytes;
    logic [2:0]  len;
    logic [3:0]  emask;
    logic        berr;
    logic [1:0]  tid;
    logic [4:0]  cfg;
    logic        bp;
    logic [7:0]  epar;
    logic [7:0]  ests;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h08040201, 3'd4, 4'b0000, 1'b0, 2'd0, 5'h00, 1'b0, 8'h0F, 8'h00},
    '{32'h00F00FFF, 3'd3, 4'b0010, 1'b0, 2'd1, 5'h00, 1'b0, 8'h00, 8'h81},
    '{32'h00005AA5, 3'd2, 4'b0000, 1'b0, 2'd2, 5'h1F, 1'b1, 8'hFF, 8'h7E},
    '{32'h00000000, 3'd0, 4'b0000, 1'b1, 2'd2, 5'h00, 1'b0, 8'h00, 8'h82},
    '{32'h78563412, 3'd4, 4'b1000, 1'b0, 2'd3, 5'h0A, 1'b1, 8'h08, 8'hAB},
    '{32'h78563412, 3'd4, 4'b0000, 1'b0, 2'd0, 5'h00, 1'b0, 8'h08, 8'h00}
  };

  int errors = 0;
  int checks = 0;
  bit bp_mode = 1'b0;
  int cyc = 0;
  int cap_n = 0;
  logic [1:0] cap_k [64];
  logic [7:0] cap_d [64];
  int last_wait = 0;
  logic       prev_hold = 1'b0;
  logic [7:0] prev_d = 8'h00;
  logic [1:0] prev_k = 2'd0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // output sink: ready pattern and capture, away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (prev_hold) chk(out_valid && out_data == prev_d && out_kind == prev_k,
                       "R7 hold", {out_kind, out_data}, {prev_k, prev_d});
    out_ready = bp_mode ? ((cyc % 3) != 0 && (cyc % 7) != 2) : 1'b1;
    prev_hold = out_valid && !out_ready;
    prev_d = out_data;
    prev_k = out_kind;
    if (out_valid && out_ready && cap_n < 64) begin
      cap_k[cap_n] = out_kind;
      cap_d[cap_n] = out_data;
      cap_n++;
    end
  end

  task automatic send(input logic [1:0] k, input logic [7:0] d, input logic e);
    int w;
    w = 0;
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_data = d; in_err = e;
    #1;
    while (!in_ready) begin
      w++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    last_wait = w;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_err = 1'b0;
  endtask

  task automatic wait_cap(input int n);
    int t;
    t = 0;
    while (cap_n < n && t < 300) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    chk(cap_n == n, "R7 count", cap_n, n);
  endtask

  task automatic run_vec(input vec_t v);
    int n;
    int eoe_wait;
    n = int'(v.len);
    type_id = v.tid; cfg_bits = v.cfg; bp_mode = v.bp;
    cap_n = 0;
    send(2'd1, 8'h00, v.berr);
    for (int i = 0; i < n; i++) send(2'd0, v.bytes[8*i +: 8], v.emask[i]);
    send(2'd2, 8'h00, 1'b0);
    eoe_wait = last_wait;
    idle();
    wait_cap(n + 4);
    chk(cap_k[0] == 2'd1, "R1 begin", cap_k[0], 1);
    for (int i = 0; i < n; i++)
      chk(cap_k[1+i] == 2'd0 && cap_d[1+i] == v.bytes[8*i +: 8], "R1 data",
          {cap_k[1+i], cap_d[1+i]}, {2'd0, v.bytes[8*i +: 8]});
    chk(cap_k[n+1] == 2'd0 && cap_d[n+1] == v.epar, "R2 parity", cap_d[n+1], v.epar);
    chk(cap_k[n+2] == 2'd0 && cap_d[n+2] == v.ests, "R3 status", cap_d[n+2], v.ests);
    chk(cap_k[n+3] == 2'd2, "R5 end marker", cap_k[n+3], 2);
    if (!v.bp) chk(eoe_wait == 2, "R6 stall", eoe_wait, 2);
    bp_mode = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8 in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 after reset", out_valid, 0);

    for (int v = 0; v < NV; v++) run_vec(VECS[v]);

    // R4: stray data and error before begin do not leak into the event
    type_id = 2'd1; cfg_bits = 5'd0; cap_n = 0;
    send(2'd0, 8'h3C, 1'b1);
    send(2'd1, 8'h00, 1'b0);
    send(2'd0, 8'h01, 1'b0);
    send(2'd2, 8'h00, 1'b0);
    idle();
    wait_cap(6);
    chk(cap_k[0] == 2'd0 && cap_d[0] == 8'h3C, "R1 stray data", cap_d[0], 8'h3C);
    chk(cap_d[3] == 8'h01, "R4 parity cleared", cap_d[3], 8'h01);
    chk(cap_d[4] == 8'h01, "R4 error cleared", cap_d[4], 8'h01);

    // R1: auxiliary kind 3 passes with its kind and enters the parity
    type_id = 2'd0; cap_n = 0; bp_mode = 1'b1;
    send(2'd1, 8'h00, 1'b0);
    send(2'd0, 8'h11, 1'b0);
    send(2'd3, 8'h55, 1'b0);
    send(2'd2, 8'h00, 1'b0);
    idle();
    wait_cap(6);
    chk(cap_k[2] == 2'd3 && cap_d[2] == 8'h55, "R1 aux kind", {cap_k[2], cap_d[2]}, {2'd3, 8'h55});
    chk(cap_d[3] == 8'h44, "R2 aux parity", cap_d[3], 8'h44);
    chk(cap_k[5] == 2'd2, "R5 aux end", cap_k[5], 2);
    bp_mode = 1'b0;

    // back-to-back events with no idle gap
    cap_n = 0; type_id = 2'd2; cfg_bits = 5'h01;
    send(2'd1, 8'h00, 1'b0);
    send(2'd0, 8'hC3, 1'b0);
    send(2'd2, 8'h00, 1'b0);
    send(2'd1, 8'h00, 1'b0);
    send(2'd0, 8'h0F, 1'b1);
    send(2'd2, 8'h00, 1'b0);
    idle();
    wait_cap(10);
    chk(cap_d[2] == 8'hC3 && cap_d[3] == 8'h06, "R3 first status", {cap_d[2], cap_d[3]}, {8'hC3, 8'h06});
    chk(cap_d[7] == 8'h0F, "R4 second parity", cap_d[7], 8'h0F);
    chk(cap_d[8] == 8'h86, "R3 second status", cap_d[8], 8'h86);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule